// File: doc/BRIEF.md
# Peak-Current PWM Cycle Generator

This block makes the gate drive pulse for one switching cycle of a peak-current-mode power converter. All of its inputs are digital. An oscillator strobe marks the start of each switching period. A feedback code carries the control loop's demand, and a current-sense code is the digitised primary current. The demand level is one third of the feedback code. It is then limited by a soft-start reference that climbs from zero to the maximum peak setpoint. The drive pulse ends when the sensed current reaches that level, but only after a leading-edge blanking interval. It also ends when a maximum on-time is reached.

At light load the block does not shrink the pulse without limit. It stops answering strobes, which gives bursts of pulses. The skip decision uses a low and a high threshold, so it has hysteresis. A registered flag shows when the current limit is cutting into the feedback demand. A restart input takes the soft-start reference back to zero. An enable input forces the drive low.

States and transitions:
- Cycle machine: `CY_OFF` (enable low) goes to `CY_IDLE` once enable is high. `CY_IDLE` goes to `CY_BLANK` on a strobe when not skipping. `CY_BLANK` goes to `CY_ON` when the blanking count ends. `CY_ON` goes to `CY_IDLE` on a current hit or when the on-time cap is reached. Enable low sends any state to `CY_OFF`.
- Soft-start machine: `SS_RAMP` goes to `SS_HOLD` when the level reaches the maximum. A restart sends either state back to `SS_RAMP` with the level at zero.
- Skip machine: `SK_RUN` goes to `SK_SKIP` when the demand is below the low threshold. `SK_SKIP` goes to `SK_RUN` when the demand is at or above the high threshold.

Top module: `pwm_cycle_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it, the drive and the error flag are low. Reset puts the soft-start level at 0 and the cycle machine in `CY_OFF`.
- R2: A strobe seen at a clock edge, with the cycle machine idle, enable high and skip inactive, raises the drive from that edge onward.
- R3: The demand is `min(fb_code/3, ss_level)`, where the division truncates. Once blanking is over, the first edge that sees `cs_code >= demand` lowers the drive.
- R4: For the first `LEB_CYC` cycles of a pulse the current comparison is ignored. A pulse therefore lasts at least `LEB_CYC+1` cycles while enable stays high.
- R5: The drive never stays high for more than `DMAX_CYC` consecutive cycles. The design requires `DMAX_CYC > LEB_CYC`.
- R6: Skip mode works on `raw = fb_code/3`. It is entered when `raw < IMAX/4`. It is left when `raw >= IMAX/4 + HYST`. Between those two values the mode holds. Strobes are ignored while skipping.
- R7: The soft-start level rises by 1 every `SS_STEP` cycles, from 0 up to `IMAX`, and then holds. A restart pulse puts it back to 0 and starts the ramp again.
- R8: The error flag is registered. It is high in the cycle after an edge that saw `raw > ss_level`.
- R9: Enable low at an edge makes the drive low from that edge onward. After enable returns, a pulse starts only on a later strobe, once the machine has passed through idle.
- R10: Ending a pulse takes priority. A strobe that arrives while the drive is high is ignored and does not lengthen or restart the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Enable; low forces the drive off |
| start_i | input | 1 | Oscillator cycle-start strobe |
| ss_restart_i | input | 1 | Restarts the soft-start ramp from zero |
| fb_code_i | input | CODE_W | Feedback demand code |
| cs_code_i | input | CODE_W | Current-sense code |
| drive_o | output | 1 | Gate drive |
| ilim_err_o | output | 1 | Flag: current limit is clamping the demand |

## Verification
The bench goes after the following corner cases.

- **Blanking.** A current-sense code held at full scale from the first cycle must still give a pulse exactly `LEB_CYC+1` cycles long. A design that compares during blanking would give a one-cycle pulse.
- **On-time cap.** A current-sense code that never reaches the demand must be cut off by the cap. A design that gets this wrong holds the drive to the next strobe or beyond.
- **Strobe period shorter than the cap.** A strobe must not re-trigger or stretch a pulse that is already running.
- **Skip hysteresis.** The bench parks the demand inside the band from both directions. A single-threshold design would toggle skip mode there.
- **Soft start.** The bench restarts the ramp in mid-operation. A design that does not re-arm would keep full-width pulses and leave the error flag low.

// File: rtl/pwm_cyc_pkg.sv
package pwm_cyc_pkg;
    typedef enum logic [1:0] {
        CY_OFF   = 2'd0,
        CY_IDLE  = 2'd1,
        CY_BLANK = 2'd2,
        CY_ON    = 2'd3
    } cyc_st_t;

    typedef enum logic {
        SS_RAMP = 1'b0,
        SS_HOLD = 1'b1
    } ss_st_t;

    typedef enum logic {
        SK_RUN  = 1'b0,
        SK_SKIP = 1'b1
    } skip_st_t;
endpackage

// File: rtl/pwm_softstart.sv
module pwm_softstart
    import pwm_cyc_pkg::*;
#(
    parameter int CODE_W  = 10,
    parameter int IMAX    = 300,
    parameter int SS_STEP = 2083
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart_i,
    output logic [CODE_W-1:0] lvl_o
);
    localparam int DIV_W = (SS_STEP > 1) ? $clog2(SS_STEP) : 1;
    localparam logic [DIV_W-1:0]  DIV_LAST = DIV_W'(SS_STEP - 1);
    localparam logic [CODE_W-1:0] LVL_TOP  = CODE_W'(IMAX);
    localparam logic [CODE_W-1:0] LVL_PRE  = CODE_W'(IMAX - 1);

    ss_st_t            st, st_nxt;
    logic [DIV_W-1:0]  div, div_nxt;
    logic [CODE_W-1:0] lvl, lvl_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= SS_RAMP;
            div <= '0;
            lvl <= '0;
        end else begin
            st  <= st_nxt;
            div <= div_nxt;
            lvl <= lvl_nxt;
        end
    end

    always_comb begin
        st_nxt  = st;
        div_nxt = div;
        lvl_nxt = lvl;
        if (restart_i) begin
            st_nxt  = SS_RAMP;
            div_nxt = '0;
            lvl_nxt = '0;
        end else begin
            unique case (st)
                SS_RAMP: begin
                    if (div == DIV_LAST) begin
                        div_nxt = '0;
                        lvl_nxt = lvl + 1'b1;
                        if (lvl == LVL_PRE) st_nxt = SS_HOLD;
                    end else begin
                        div_nxt = div + 1'b1;
                    end
                end
                SS_HOLD: begin
                    lvl_nxt = lvl;
                end
                default: st_nxt = SS_RAMP;
            endcase
        end
    end

    always_comb lvl_o = lvl;

    assert_ss_cap_R7: assert property (@(posedge clk) disable iff (rst)
        lvl_o <= LVL_TOP);

    assert_ss_step_R7: assert property (@(posedge clk) disable iff (rst)
        !restart_i |=> (lvl_o == $past(lvl_o)) || (lvl_o == $past(lvl_o) + 1'b1));
endmodule

// File: rtl/pwm_demand.sv
module pwm_demand
    import pwm_cyc_pkg::*;
#(
    parameter int CODE_W = 10,
    parameter int IMAX   = 300,
    parameter int HYST   = 25
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] fb_i,
    input  logic [CODE_W-1:0] ss_lvl_i,
    output logic [CODE_W-1:0] dem_o,
    output logic              skip_o,
    output logic              err_o
);
    localparam logic [CODE_W-1:0] SKIP_LO = CODE_W'(IMAX / 4);
    localparam logic [CODE_W-1:0] SKIP_HI = CODE_W'(IMAX / 4 + HYST);

    skip_st_t          sk, sk_nxt;
    logic [CODE_W-1:0] raw;
    logic              err_q;

    always_comb raw   = fb_i / CODE_W'(3);
    always_comb dem_o = (raw < ss_lvl_i) ? raw : ss_lvl_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            sk    <= SK_RUN;
            err_q <= 1'b0;
        end else begin
            sk    <= sk_nxt;
            err_q <= (raw > ss_lvl_i);
        end
    end

    always_comb begin
        sk_nxt = sk;
        unique case (sk)
            SK_RUN:  if (raw < SKIP_LO)  sk_nxt = SK_SKIP;
            SK_SKIP: if (raw >= SKIP_HI) sk_nxt = SK_RUN;
            default: sk_nxt = SK_RUN;
        endcase
    end

    always_comb begin
        skip_o = (sk == SK_SKIP);
        err_o  = err_q;
    end

    assert_skip_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (skip_o && raw >= SKIP_LO && raw < SKIP_HI) |=> skip_o);

    assert_run_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!skip_o && raw >= SKIP_LO) |=> !skip_o);
endmodule

// File: rtl/pwm_cycle_fsm.sv
module pwm_cycle_fsm
    import pwm_cyc_pkg::*;
#(
    parameter int CODE_W   = 10,
    parameter int LEB_CYC  = 63,
    parameter int DMAX_CYC = 3077
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              start_i,
    input  logic              skip_i,
    input  logic [CODE_W-1:0] cs_i,
    input  logic [CODE_W-1:0] dem_i,
    output logic              drive_o
);
    localparam int CNT_W = $clog2(DMAX_CYC + 1);
    localparam logic [CNT_W-1:0] LEB_LAST  = CNT_W'(LEB_CYC - 1);
    localparam logic [CNT_W-1:0] DMAX_LAST = CNT_W'(DMAX_CYC - 1);

    cyc_st_t          st, st_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic             cs_hit;

    always_comb cs_hit = (cs_i >= dem_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= CY_OFF;
            cnt <= '0;
        end else begin
            st  <= st_nxt;
            cnt <= cnt_nxt;
        end
    end

    always_comb begin
        st_nxt  = st;
        cnt_nxt = cnt;
        if (!en_i) begin
            st_nxt  = CY_OFF;
            cnt_nxt = '0;
        end else begin
            unique case (st)
                CY_OFF: st_nxt = CY_IDLE;
                CY_IDLE: begin
                    if (start_i && !skip_i) begin
                        st_nxt  = CY_BLANK;
                        cnt_nxt = '0;
                    end
                end
                CY_BLANK: begin
                    cnt_nxt = cnt + 1'b1;
                    if (cnt == LEB_LAST) st_nxt = CY_ON;
                end
                CY_ON: begin
                    if (cs_hit || cnt == DMAX_LAST) begin
                        st_nxt  = CY_IDLE;
                        cnt_nxt = '0;
                    end else begin
                        cnt_nxt = cnt + 1'b1;
                    end
                end
                default: st_nxt = CY_OFF;
            endcase
        end
    end

    always_comb drive_o = (st == CY_BLANK) || (st == CY_ON);

    assert_blank_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (st == CY_BLANK && en_i) |=> drive_o);

    assert_skip_blocks_R6: assert property (@(posedge clk) disable iff (rst)
        (st == CY_IDLE && skip_i) |=> !drive_o);

    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (st == CY_ON && cs_hit && start_i) |=> !drive_o);
endmodule

// File: rtl/pwm_cycle_gen.sv
module pwm_cycle_gen
    import pwm_cyc_pkg::*;
#(
    parameter int CODE_W   = 10,
    parameter int IMAX     = 300,
    parameter int SS_STEP  = 2083,
    parameter int HYST     = 25,
    parameter int LEB_CYC  = 63,
    parameter int DMAX_CYC = 3077
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic              start_i,
    input  logic              ss_restart_i,
    input  logic [CODE_W-1:0] fb_code_i,
    input  logic [CODE_W-1:0] cs_code_i,
    output logic              drive_o,
    output logic              ilim_err_o
);
    localparam int PL_W = $clog2(DMAX_CYC + 2);

    logic [CODE_W-1:0] ss_lvl;
    logic [CODE_W-1:0] dem;
    logic              skip;

    pwm_softstart #(.CODE_W(CODE_W), .IMAX(IMAX), .SS_STEP(SS_STEP)) u_ss (
        .clk       (clk),
        .rst       (rst),
        .restart_i (ss_restart_i),
        .lvl_o     (ss_lvl)
    );

    pwm_demand #(.CODE_W(CODE_W), .IMAX(IMAX), .HYST(HYST)) u_dem (
        .clk      (clk),
        .rst      (rst),
        .fb_i     (fb_code_i),
        .ss_lvl_i (ss_lvl),
        .dem_o    (dem),
        .skip_o   (skip),
        .err_o    (ilim_err_o)
    );

    pwm_cycle_fsm #(.CODE_W(CODE_W), .LEB_CYC(LEB_CYC), .DMAX_CYC(DMAX_CYC)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .en_i    (en_i),
        .start_i (start_i),
        .skip_i  (skip),
        .cs_i    (cs_code_i),
        .dem_i   (dem),
        .drive_o (drive_o)
    );

    logic [PL_W-1:0] plen;
    always_ff @(posedge clk) begin
        if (rst)          plen <= '0;
        else if (drive_o) plen <= plen + 1'b1;
        else              plen <= '0;
    end

    assert_duty_cap_R5: assert property (@(posedge clk) disable iff (rst)
        drive_o |-> plen < PL_W'(DMAX_CYC));

    assert_enable_off_R9: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !drive_o);

    assert_err_tracks_R8: assert property (@(posedge clk) disable iff (rst)
        ss_restart_i && fb_code_i >= CODE_W'(3) |=> ##1 ilim_err_o);
endmodule

// File: tb/sim_pwm_cycle_gen.sv
module sim_pwm_cycle_gen;
    localparam int CW = 10, IMAX = 200, SSTEP = 2, HYST = 10, LEB = 3, DMAX = 16;

    logic clk = 1'b0, rst = 1'b1, en = 1'b0, start = 1'b0, rstrt = 1'b0;
    logic [CW-1:0] fb = '0, cs = '0;
    logic drive, err;

    always #2 clk = ~clk;

    pwm_cycle_gen #(.CODE_W(CW), .IMAX(IMAX), .SS_STEP(SSTEP), .HYST(HYST),
                    .LEB_CYC(LEB), .DMAX_CYC(DMAX)) u0 (
        .clk(clk), .rst(rst), .en_i(en), .start_i(start), .ss_restart_i(rstrt),
        .fb_code_i(fb), .cs_code_i(cs), .drive_o(drive), .ilim_err_o(err));

    int checks = 0, fails = 0;
    string req = "R1";
    bit done = 0;
    int per = 20, slope = 20, ph = 0;

    // stimulus waveform: strobe and current ramp per period
    always @(negedge clk) begin
        if (rst) ph = 0; else ph = (ph + 1) % per;
        start = (ph == 0) && !rst;
        cs = (ph * slope > 1023) ? 10'd1023 : CW'(ph * slope);
    end

    // behavioural reference model
    int m_ss = 0, m_div = 0, m_skip = 0, m_on = 0, m_off = 1, m_cnt = 0, m_err = 0;
    always @(posedge clk) begin
        int raw, dem, lo, hi;
        if (rst) begin
            m_ss = 0; m_div = 0; m_skip = 0; m_on = 0; m_off = 1; m_cnt = 0; m_err = 0;
        end else begin
            raw = int'(fb) / 3;
            dem = (raw < m_ss) ? raw : m_ss;
            lo = IMAX / 4; hi = IMAX / 4 + HYST;
            if (!en) begin m_on = 0; m_off = 1; m_cnt = 0; end
            else if (m_off) m_off = 0;
            else if (!m_on) begin
                if (start && !m_skip) begin m_on = 1; m_cnt = 0; end
            end else begin
                if ((m_cnt >= LEB && int'(cs) >= dem) || m_cnt == DMAX - 1) begin
                    m_on = 0; m_cnt = 0;
                end else m_cnt++;
            end
            m_err = (raw > m_ss);
            if (raw < lo) m_skip = 1; else if (raw >= hi) m_skip = 0;
            if (rstrt) begin m_ss = 0; m_div = 0; end
            else if (m_ss < IMAX) begin
                if (m_div == SSTEP - 1) begin m_div = 0; m_ss++; end else m_div++;
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (drive !== 1'(m_on) || err !== 1'(m_err)) begin
                fails++;
                $display("FAIL %s drive/err actual %b/%b expected %0d/%0d at %0t",
                         req, drive, err, m_on, m_err, $time);
            end
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_up;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        req = "R1";
        run(3);
        rst = 1'b0;
        run(3);
        req = "R7"; en = 1'b1; fb = 10'd1023; slope = 20; run(500);
        req = "R2"; fb = 10'd360; run(60);
        req = "R3"; run(140);
        req = "R5"; slope = 0; run(100);
        req = "R4"; slope = 1023; run(100);
        req = "R6"; slope = 20; fb = 10'd120; run(100);
        fb = 10'd165; run(100);
        fb = 10'd210; run(100);
        fb = 10'd165; run(100);
        req = "R8"; fb = 10'd360; rstrt = 1'b1; run(1); rstrt = 1'b0; run(120);
        req = "R10"; per = 12; slope = 0; run(100);
        per = 20; slope = 20; run(30);
        req = "R9"; run(7); en = 1'b0; run(30); en = 1'b1; run(60);
        done = 1;
        finish_up();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual hung expected finished");
            finish_up();
        end
    end
endmodule